// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block keeps recently used virtual-to-physical page translations for a 32-bit virtual space that is split into 16 KB pages. It is organised as 64 sets of two ways. Each stored entry holds a valid flag, a lock flag, the 18-bit virtual page tag, an 8-bit context identifier, an 18-bit physical page number and 8 attribute bits. A lookup presents a virtual address and a context identifier, and one clock later the block reports hit or miss together with the physical page and the attributes.

A fill port installs a translation, and the block chooses the way. A lock flag on an entry keeps it out of replacement, so a fixed virtual slot keeps pointing at a pinned page until software ejects it. An eject port removes the entry that matches a page and context, whether or not it is locked. A one-cycle flush drops every unlocked entry. Next to the array sits a single extension entry that a miss handler can load directly. Every lookup checks it in parallel with the array, and it wins when both match.

Maintenance requests go through a command selector, which has four named states evaluated each cycle: `CMD_IDLE`, `CMD_FLUSH`, `CMD_EJECT` and `CMD_FILL`. A flush request moves the selector to `CMD_FLUSH` ahead of everything else. An eject request moves it to `CMD_EJECT` when no flush is pending. A fill request moves it to `CMD_FILL` when neither of the others is pending. With no request it stays in `CMD_IDLE`. Lookups run beside the selector and always see the contents as they stood before the current clock edge.

Top module: `xlat_buf2w`

## Requirements
- R1: After reset every entry and the extension entry are invalid and all outputs are low. A lookup result appears on the clock edge after the request, with `lk_vld` high in that cycle. On a miss, `lk_ppn` and `lk_attr` are zero.
- R2: The set is selected by virtual address bits [19:14]. The stored tag is bits [31:14], and bits [13:0] take no part in matching.
- R3: A hit needs a valid entry whose tag and context identifier both equal those of the lookup.
- R4: A fill whose page and context already sit in the set overwrites that way in place. Otherwise it uses an invalid way, with way 0 taken before way 1.
- R5: When both ways are valid and unlocked, a fill replaces the least recently used way. A lookup hit or a fill marks its way as most recently used.
- R6: A locked way is never replaced. If the least recently used way is locked, the other way is taken.
- R7: A fill into a set whose two ways are both valid, locked and not matching is refused. `wr_err` pulses high on the next clock edge, and the set keeps its contents.
- R8: An eject clears the entry matching the given page and context even if it is locked, leaves the other way untouched, and also clears the extension entry if that entry matches.
- R9: A flush clears every unlocked entry and the extension entry in one cycle. Locked entries keep translating.
- R10: Loading the extension entry makes lookups of that page and context hit with its physical page and attributes from the next cycle on.
- R11: When the extension entry and an array entry both match a lookup, the result comes from the extension entry.
- R12: When requests arrive together, flush beats eject and eject beats fill, and the losing requests are dropped. A lookup in the same cycle as a fill sees the state before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup context identifier |
| lk_vld | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 18 | Physical page number of the hit |
| lk_attr | output | 8 | Attribute bits of the hit |
| wr_req | input | 1 | Fill request |
| wr_va | input | 32 | Fill virtual address |
| wr_ctx | input | 8 | Fill context identifier |
| wr_ppn | input | 18 | Fill physical page number |
| wr_attr | input | 8 | Fill attribute bits |
| wr_lock | input | 1 | Fill as a locked entry |
| wr_err | output | 1 | Fill refused: both ways locked |
| inv_req | input | 1 | Eject request |
| inv_va | input | 32 | Eject virtual address |
| inv_ctx | input | 8 | Eject context identifier |
| flush_req | input | 1 | Flush all unlocked entries |
| ext_ld | input | 1 | Load the extension entry |
| ext_va | input | 32 | Extension entry virtual address |
| ext_ctx | input | 8 | Extension entry context identifier |
| ext_ppn | input | 18 | Extension entry physical page number |
| ext_attr | input | 8 | Extension entry attribute bits |

## Verification
Lookup outputs and `wr_err` come from registers, so each result is due exactly one clock edge after its request. The bench drives every request on a falling edge and reads the result one nanosecond after the next rising edge. Fills, ejects, flushes and extension loads take effect on that same edge, so a lookup issued in the following cycle is the first to observe them. The bench also issues a lookup in the same cycle as a fill and checks that it does not see the new entry. Replacement checks first pin each set's least-recently-used state with a known series of fills and hits, then predict the victim.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 14;
    localparam int TAG_W    = VA_W - PG_SHIFT;
    localparam int CTX_W    = 8;
    localparam int PPN_W    = 18;
    localparam int ATTR_W   = 8;

    typedef struct packed {
        logic              vld;
        logic              lck;
        logic [TAG_W-1:0]  tag;
        logic [CTX_W-1:0]  ctx;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } xent_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_FLUSH = 2'd1,
        CMD_EJECT = 2'd2,
        CMD_FILL  = 2'd3
    } cmd_e;
endpackage

// File: rtl/xlat_way_bank.sv
module xlat_way_bank
    import xlat_pkg::*;
#(
    parameter int SET_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] rd_idx,
    input  logic [SET_BITS-1:0] mt_idx,
    input  logic                fill_en,
    input  xent_t               fill_ent,
    input  logic                eject_en,
    input  logic                flush_en,
    output xent_t               rd_ent,
    output xent_t               mt_ent
);
    localparam int NUM_SETS = 1 << SET_BITS;

    xent_t mem [NUM_SETS];

    assign rd_ent = mem[rd_idx];
    assign mt_ent = mem[mt_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (flush_en) begin
                // locked entries ride through a flush
                for (int i = 0; i < NUM_SETS; i++) begin
                    if (!mem[i].lck) begin
                        mem[i].vld <= 1'b0;
                    end
                end
            end
            if (eject_en) begin
                mem[mt_idx].vld <= 1'b0;
                mem[mt_idx].lck <= 1'b0;
            end
            if (fill_en) begin
                mem[mt_idx] <= fill_ent;
            end
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim (
    input  logic [1:0] vld,
    input  logic [1:0] lck,
    input  logic [1:0] match,
    input  logic       lru,
    output logic       way,
    output logic       ok
);
    always_comb begin
        way = 1'b0;
        ok  = 1'b1;
        if (match[0]) begin
            way = 1'b0;
        end else if (match[1]) begin
            way = 1'b1;
        end else if (!vld[0]) begin
            way = 1'b0;
        end else if (!vld[1]) begin
            way = 1'b1;
        end else if (lck[0] && lck[1]) begin
            ok  = 1'b0;
        end else if (lck[lru]) begin
            way = ~lru;
        end else begin
            way = lru;
        end
    end
endmodule

// File: rtl/xlat_ext_reg.sv
module xlat_ext_reg
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [CTX_W-1:0]  ld_ctx,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic [ATTR_W-1:0] ld_attr,
    input  logic              ej,
    input  logic [TAG_W-1:0]  ej_tag,
    input  logic [CTX_W-1:0]  ej_ctx,
    input  logic [TAG_W-1:0]  q_tag,
    input  logic [CTX_W-1:0]  q_ctx,
    output logic              hit,
    output logic [PPN_W-1:0]  ppn,
    output logic [ATTR_W-1:0] attr
);
    xent_t ent_q;
    logic  ej_match;

    assign ej_match = ent_q.vld && ent_q.tag == ej_tag && ent_q.ctx == ej_ctx;
    assign hit      = ent_q.vld && ent_q.tag == q_tag && ent_q.ctx == q_ctx;
    assign ppn      = ent_q.ppn;
    assign attr     = ent_q.attr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (clr) begin
            ent_q.vld <= 1'b0;
        end else if (ld) begin
            ent_q <= '{vld: 1'b1, lck: 1'b0, tag: ld_tag, ctx: ld_ctx,
                       ppn: ld_ppn, attr: ld_attr};
        end else if (ej && ej_match) begin
            ent_q.vld <= 1'b0;
        end
    end
endmodule

// File: rtl/xlat_buf2w.sv
module xlat_buf2w
    import xlat_pkg::*;
#(
    parameter int SET_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_vld,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              wr_req,
    input  logic [VA_W-1:0]   wr_va,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_lock,
    output logic              wr_err,
    input  logic              inv_req,
    input  logic [VA_W-1:0]   inv_va,
    input  logic [CTX_W-1:0]  inv_ctx,
    input  logic              flush_req,
    input  logic              ext_ld,
    input  logic [VA_W-1:0]   ext_va,
    input  logic [CTX_W-1:0]  ext_ctx,
    input  logic [PPN_W-1:0]  ext_ppn,
    input  logic [ATTR_W-1:0] ext_attr
);
    localparam int NUM_SETS = 1 << SET_BITS;
    localparam int NUM_WAYS = 2;
    localparam int IDX_LO   = PG_SHIFT;
    localparam int IDX_HI   = PG_SHIFT + SET_BITS - 1;

    // ---------------- address split ----------------
    logic [SET_BITS-1:0] lk_idx, mt_idx;
    logic [TAG_W-1:0]    lk_tag, mt_tag, ext_tag;
    logic [VA_W-1:0]     mt_va;
    logic [CTX_W-1:0]    mt_ctx;

    assign mt_va   = inv_req ? inv_va  : wr_va;
    assign mt_ctx  = inv_req ? inv_ctx : wr_ctx;
    assign lk_idx  = lk_va[IDX_HI:IDX_LO];
    assign mt_idx  = mt_va[IDX_HI:IDX_LO];
    assign lk_tag  = lk_va[VA_W-1:PG_SHIFT];
    assign mt_tag  = mt_va[VA_W-1:PG_SHIFT];
    assign ext_tag = ext_va[VA_W-1:PG_SHIFT];

    logic unused_offsets;
    assign unused_offsets = ^{lk_va[PG_SHIFT-1:0], mt_va[PG_SHIFT-1:0],
                              ext_va[PG_SHIFT-1:0]};

    // ---------------- command selector ----------------
    cmd_e cmd;
    logic                flush_en;
    logic [NUM_WAYS-1:0] fill_en, eject_en;
    logic                ext_ej;
    logic                vic_way, vic_ok;
    logic [NUM_WAYS-1:0] mt_match, lk_match, mt_vld, mt_lck;

    always_comb begin
        if (flush_req) begin
            cmd = CMD_FLUSH;
        end else if (inv_req) begin
            cmd = CMD_EJECT;
        end else if (wr_req) begin
            cmd = CMD_FILL;
        end else begin
            cmd = CMD_IDLE;
        end
    end

    always_comb begin
        flush_en = 1'b0;
        fill_en  = '0;
        eject_en = '0;
        ext_ej   = 1'b0;
        unique case (cmd)
            CMD_IDLE: begin
            end
            CMD_FLUSH: begin
                flush_en = 1'b1;
            end
            CMD_EJECT: begin
                eject_en = mt_match;
                ext_ej   = 1'b1;
            end
            CMD_FILL: begin
                fill_en[vic_way] = vic_ok;
            end
            default: begin
            end
        endcase
    end

    // ---------------- way banks ----------------
    xent_t rd_ent [NUM_WAYS];
    xent_t mt_ent [NUM_WAYS];
    xent_t new_ent;

    assign new_ent = '{vld: 1'b1, lck: wr_lock, tag: mt_tag, ctx: wr_ctx,
                       ppn: wr_ppn, attr: wr_attr};

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        xlat_way_bank #(
            .SET_BITS (SET_BITS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (lk_idx),
            .mt_idx   (mt_idx),
            .fill_en  (fill_en[w]),
            .fill_ent (new_ent),
            .eject_en (eject_en[w]),
            .flush_en (flush_en),
            .rd_ent   (rd_ent[w]),
            .mt_ent   (mt_ent[w])
        );
        assign lk_match[w] = rd_ent[w].vld && rd_ent[w].tag == lk_tag
                             && rd_ent[w].ctx == lk_ctx;
        assign mt_match[w] = mt_ent[w].vld && mt_ent[w].tag == mt_tag
                             && mt_ent[w].ctx == mt_ctx;
        assign mt_vld[w]   = mt_ent[w].vld;
        assign mt_lck[w]   = mt_ent[w].lck;
    end

    // ---------------- replacement ----------------
    logic [NUM_SETS-1:0] lru_q;

    xlat_victim u_victim (
        .vld   (mt_vld),
        .lck   (mt_lck),
        .match (mt_match),
        .lru   (lru_q[mt_idx]),
        .way   (vic_way),
        .ok    (vic_ok)
    );

    logic  arr_hit, arr_way;
    xent_t arr_ent;

    assign arr_hit = |lk_match;
    assign arr_way = lk_match[1];
    assign arr_ent = rd_ent[arr_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_req && arr_hit) begin
                lru_q[lk_idx] <= ~arr_way;
            end
            if (|fill_en) begin
                lru_q[mt_idx] <= ~vic_way;
            end
        end
    end

    // ---------------- extension entry ----------------
    logic              ext_hit;
    logic [PPN_W-1:0]  ext_q_ppn;
    logic [ATTR_W-1:0] ext_q_attr;

    xlat_ext_reg u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush_en),
        .ld      (ext_ld),
        .ld_tag  (ext_tag),
        .ld_ctx  (ext_ctx),
        .ld_ppn  (ext_ppn),
        .ld_attr (ext_attr),
        .ej      (ext_ej),
        .ej_tag  (mt_tag),
        .ej_ctx  (mt_ctx),
        .q_tag   (lk_tag),
        .q_ctx   (lk_ctx),
        .hit     (ext_hit),
        .ppn     (ext_q_ppn),
        .attr    (ext_q_attr)
    );

    // ---------------- registered results ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_vld  <= 1'b0;
            lk_hit  <= 1'b0;
            lk_ppn  <= '0;
            lk_attr <= '0;
            wr_err  <= 1'b0;
        end else begin
            lk_vld <= lk_req;
            lk_hit <= lk_req && (ext_hit || arr_hit);
            if (lk_req && ext_hit) begin
                lk_ppn  <= ext_q_ppn;
                lk_attr <= ext_q_attr;
            end else if (lk_req && arr_hit) begin
                lk_ppn  <= arr_ent.ppn;
                lk_attr <= arr_ent.attr;
            end else begin
                lk_ppn  <= '0;
                lk_attr <= '0;
            end
            wr_err <= (cmd == CMD_FILL) && !vic_ok;
        end
    end
endmodule

// File: rtl/xlat_buf2w_chk.sv
module xlat_buf2w_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_va,
    input logic [CTX_W-1:0]  lk_ctx,
    input logic              lk_vld,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [ATTR_W-1:0] lk_attr,
    input logic              wr_req,
    input logic              wr_err,
    input logic              inv_req,
    input logic              flush_req,
    input logic              ext_ld,
    input logic [VA_W-1:0]   ext_va,
    input logic [CTX_W-1:0]  ext_ctx,
    input logic [PPN_W-1:0]  ext_ppn
);
    // R1
    hit_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_vld);

    // R1
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vld |-> $past(lk_req));

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !lk_hit) |-> (lk_ppn == '0 && lk_attr == '0));

    // R7
    err_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_req && !inv_req && !flush_req));

    // R12
    flush_drops_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !wr_err);

    // R11
    ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_ld, 2) && $past(lk_req) && !$past(ext_ld)
         && !$past(flush_req) && !$past(inv_req)
         && $past(lk_va[VA_W-1:PG_SHIFT]) == $past(ext_va[VA_W-1:PG_SHIFT], 2)
         && $past(lk_ctx) == $past(ext_ctx, 2))
        |-> (lk_hit && lk_ppn == $past(ext_ppn, 2)));
endmodule

bind xlat_buf2w xlat_buf2w_chk u_chk (.*);

// File: tb/xlat_buf2w_tb.sv
`timescale 1ns/1ps
module xlat_buf2w_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [31:0] lk_va;
    logic [7:0]  lk_ctx;
    logic        lk_vld, lk_hit;
    logic [17:0] lk_ppn;
    logic [7:0]  lk_attr;
    logic        wr_req;
    logic [31:0] wr_va;
    logic [7:0]  wr_ctx;
    logic [17:0] wr_ppn;
    logic [7:0]  wr_attr;
    logic        wr_lock, wr_err;
    logic        inv_req;
    logic [31:0] inv_va;
    logic [7:0]  inv_ctx;
    logic        flush_req;
    logic        ext_ld;
    logic [31:0] ext_va;
    logic [7:0]  ext_ctx;
    logic [17:0] ext_ppn;
    logic [7:0]  ext_attr;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    xlat_buf2w u_dut (.*);

    function automatic logic [31:0] mkva(input logic [11:0] hi, input logic [5:0] idx);
        return {hi, idx, 14'h0A5};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_look(input string req, input logic [31:0] va, input logic [7:0] ctx,
                           input logic hit, input logic [17:0] ppn, input logic [7:0] attr);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_ctx = ctx;
        @(posedge clk); #1;
        lk_req = 1'b0;
        chk(req, "lk_vld", 32'(lk_vld), 32'd1);
        chk(req, "lk_hit", 32'(lk_hit), 32'(hit));
        chk(req, "lk_ppn", 32'(lk_ppn), 32'(ppn));
        chk(req, "lk_attr", 32'(lk_attr), 32'(attr));
    endtask

    task automatic do_fill(input string req, input logic [31:0] va, input logic [7:0] ctx,
                           input logic [17:0] ppn, input logic [7:0] attr,
                           input logic lock, input logic err);
        @(negedge clk);
        wr_req = 1'b1; wr_va = va; wr_ctx = ctx; wr_ppn = ppn;
        wr_attr = attr; wr_lock = lock;
        @(posedge clk); #1;
        wr_req = 1'b0;
        chk(req, "wr_err", 32'(wr_err), 32'(err));
    endtask

    task automatic do_eject(input logic [31:0] va, input logic [7:0] ctx);
        @(negedge clk);
        inv_req = 1'b1; inv_va = va; inv_ctx = ctx;
        @(posedge clk); #1;
        inv_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
    endtask

    task automatic do_ext(input logic [31:0] va, input logic [7:0] ctx,
                          input logic [17:0] ppn, input logic [7:0] attr);
        @(negedge clk);
        ext_ld = 1'b1; ext_va = va; ext_ctx = ctx; ext_ppn = ppn; ext_attr = attr;
        @(posedge clk); #1;
        ext_ld = 1'b0;
    endtask

    // R1 reset state
    task automatic t_reset();
        @(negedge clk);
        chk("R1", "reset lk_vld", 32'(lk_vld), 32'd0);
        chk("R1", "reset lk_hit", 32'(lk_hit), 32'd0);
        chk("R1", "reset wr_err", 32'(wr_err), 32'd0);
        rst_n = 1'b1;
        do_look("R1", mkva(12'h001, 6'd5), 8'd3, 1'b0, 18'h0, 8'h0);
    endtask

    // R2 R3 R4 basic fill and match
    task automatic t_basic();
        do_fill("R4", mkva(12'h001, 6'd5), 8'd3, 18'h00100, 8'h11, 1'b0, 1'b0);
        do_fill("R4", mkva(12'h002, 6'd5), 8'd3, 18'h00200, 8'h22, 1'b0, 1'b0);
        do_look("R2", mkva(12'h001, 6'd5), 8'd3, 1'b1, 18'h00100, 8'h11);
        do_look("R2", mkva(12'h002, 6'd5) ^ 32'h0000_3F0F, 8'd3, 1'b1, 18'h00200, 8'h22);
        do_look("R3", mkva(12'h001, 6'd5), 8'd4, 1'b0, 18'h0, 8'h0);
        do_look("R2", mkva(12'h001, 6'd6), 8'd3, 1'b0, 18'h0, 8'h0);
    endtask

    // R5 least recently used replacement
    task automatic t_repl();
        do_look("R5", mkva(12'h001, 6'd5), 8'd3, 1'b1, 18'h00100, 8'h11);
        do_fill("R5", mkva(12'h003, 6'd5), 8'd3, 18'h00300, 8'h33, 1'b0, 1'b0);
        do_look("R5", mkva(12'h001, 6'd5), 8'd3, 1'b1, 18'h00100, 8'h11);
        do_look("R5", mkva(12'h002, 6'd5), 8'd3, 1'b0, 18'h0, 8'h0);
        do_look("R5", mkva(12'h003, 6'd5), 8'd3, 1'b1, 18'h00300, 8'h33);
    endtask

    // R4 overwrite in place
    task automatic t_inplace();
        do_fill("R4", mkva(12'h001, 6'd7), 8'd1, 18'h00010, 8'h01, 1'b0, 1'b0);
        do_fill("R4", mkva(12'h002, 6'd7), 8'd1, 18'h00020, 8'h02, 1'b0, 1'b0);
        do_fill("R4", mkva(12'h001, 6'd7), 8'd1, 18'h00011, 8'h03, 1'b0, 1'b0);
        do_look("R4", mkva(12'h001, 6'd7), 8'd1, 1'b1, 18'h00011, 8'h03);
        do_look("R4", mkva(12'h002, 6'd7), 8'd1, 1'b1, 18'h00020, 8'h02);
    endtask

    // R7 refusal when both locked
    task automatic t_lock_both();
        do_fill("R7", mkva(12'h001, 6'd9), 8'd2, 18'h00901, 8'h91, 1'b1, 1'b0);
        do_fill("R7", mkva(12'h002, 6'd9), 8'd2, 18'h00902, 8'h92, 1'b1, 1'b0);
        do_fill("R7", mkva(12'h003, 6'd9), 8'd2, 18'h00903, 8'h93, 1'b0, 1'b1);
        do_look("R7", mkva(12'h001, 6'd9), 8'd2, 1'b1, 18'h00901, 8'h91);
        do_look("R7", mkva(12'h002, 6'd9), 8'd2, 1'b1, 18'h00902, 8'h92);
        do_look("R7", mkva(12'h003, 6'd9), 8'd2, 1'b0, 18'h0, 8'h0);
    endtask

    // R6 locked way skipped
    task automatic t_lock_one();
        do_fill("R6", mkva(12'h001, 6'd10), 8'd2, 18'h00A01, 8'hA1, 1'b1, 1'b0);
        do_fill("R6", mkva(12'h002, 6'd10), 8'd2, 18'h00A02, 8'hA2, 1'b0, 1'b0);
        do_look("R6", mkva(12'h002, 6'd10), 8'd2, 1'b1, 18'h00A02, 8'hA2);
        do_fill("R6", mkva(12'h003, 6'd10), 8'd2, 18'h00A03, 8'hA3, 1'b0, 1'b0);
        do_look("R6", mkva(12'h001, 6'd10), 8'd2, 1'b1, 18'h00A01, 8'hA1);
        do_look("R6", mkva(12'h002, 6'd10), 8'd2, 1'b0, 18'h0, 8'h0);
        do_look("R6", mkva(12'h003, 6'd10), 8'd2, 1'b1, 18'h00A03, 8'hA3);
    endtask

    // R8 eject of a locked entry
    task automatic t_eject();
        do_eject(mkva(12'h001, 6'd9), 8'd2);
        do_look("R8", mkva(12'h001, 6'd9), 8'd2, 1'b0, 18'h0, 8'h0);
        do_look("R8", mkva(12'h002, 6'd9), 8'd2, 1'b1, 18'h00902, 8'h92);
        do_fill("R8", mkva(12'h003, 6'd9), 8'd2, 18'h00903, 8'h93, 1'b0, 1'b0);
        do_look("R8", mkva(12'h003, 6'd9), 8'd2, 1'b1, 18'h00903, 8'h93);
    endtask

    // R9 flush keeps locked entries
    task automatic t_flush();
        do_flush();
        do_look("R9", mkva(12'h001, 6'd5), 8'd3, 1'b0, 18'h0, 8'h0);
        do_look("R9", mkva(12'h003, 6'd5), 8'd3, 1'b0, 18'h0, 8'h0);
        do_look("R9", mkva(12'h002, 6'd9), 8'd2, 1'b1, 18'h00902, 8'h92);
        do_look("R9", mkva(12'h003, 6'd9), 8'd2, 1'b0, 18'h0, 8'h0);
        do_look("R9", mkva(12'h001, 6'd10), 8'd2, 1'b1, 18'h00A01, 8'hA1);
        do_look("R9", mkva(12'h003, 6'd10), 8'd2, 1'b0, 18'h0, 8'h0);
    endtask

    // R10 R11 extension entry
    task automatic t_ext();
        do_ext(mkva(12'h007, 6'd20), 8'd1, 18'h00777, 8'h77);
        do_look("R10", mkva(12'h007, 6'd20), 8'd1, 1'b1, 18'h00777, 8'h77);
        do_look("R10", mkva(12'h007, 6'd20), 8'd2, 1'b0, 18'h0, 8'h0);
        do_fill("R11", mkva(12'h005, 6'd12), 8'd2, 18'h00300, 8'h30, 1'b0, 1'b0);
        do_look("R11", mkva(12'h005, 6'd12), 8'd2, 1'b1, 18'h00300, 8'h30);
        do_ext(mkva(12'h005, 6'd12), 8'd2, 18'h003AB, 8'h5A);
        do_look("R11", mkva(12'h005, 6'd12), 8'd2, 1'b1, 18'h003AB, 8'h5A);
        do_eject(mkva(12'h005, 6'd12), 8'd2);
        do_look("R8", mkva(12'h005, 6'd12), 8'd2, 1'b0, 18'h0, 8'h0);
        do_ext(mkva(12'h007, 6'd20), 8'd1, 18'h00777, 8'h77);
        do_flush();
        do_look("R9", mkva(12'h007, 6'd20), 8'd1, 1'b0, 18'h0, 8'h0);
    endtask

    // R12 simultaneous requests
    task automatic t_prio();
        @(negedge clk);
        wr_req = 1'b1; wr_va = mkva(12'h001, 6'd30); wr_ctx = 8'd5;
        wr_ppn = 18'h01E01; wr_attr = 8'hE1; wr_lock = 1'b0; flush_req = 1'b1;
        @(posedge clk); #1;
        wr_req = 1'b0; flush_req = 1'b0;
        chk("R12", "wr_err on flush", 32'(wr_err), 32'd0);
        do_look("R12", mkva(12'h001, 6'd30), 8'd5, 1'b0, 18'h0, 8'h0);
        @(negedge clk);
        wr_req = 1'b1; inv_req = 1'b1; inv_va = mkva(12'h009, 6'd30); inv_ctx = 8'd5;
        @(posedge clk); #1;
        wr_req = 1'b0; inv_req = 1'b0;
        do_look("R12", mkva(12'h001, 6'd30), 8'd5, 1'b0, 18'h0, 8'h0);
        @(negedge clk);
        wr_req = 1'b1; lk_req = 1'b1; lk_va = mkva(12'h001, 6'd30); lk_ctx = 8'd5;
        @(posedge clk); #1;
        wr_req = 1'b0; lk_req = 1'b0;
        chk("R12", "same-cycle lookup hit", 32'(lk_hit), 32'd0);
        do_look("R12", mkva(12'h001, 6'd30), 8'd5, 1'b1, 18'h01E01, 8'hE1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; lk_ctx = '0;
        wr_req = 1'b0; wr_va = '0; wr_ctx = '0; wr_ppn = '0; wr_attr = '0; wr_lock = 1'b0;
        inv_req = 1'b0; inv_va = '0; inv_ctx = '0; flush_req = 1'b0;
        ext_ld = 1'b0; ext_va = '0; ext_ctx = '0; ext_ppn = '0; ext_attr = '0;
        repeat (4) @(posedge clk);
        t_reset();
        t_basic();
        t_repl();
        t_inplace();
        t_lock_both();
        t_lock_one();
        t_eject();
        t_flush();
        t_ext();
        t_prio();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule